// File: doc/BRIEF.md
# ATA Task-File Address Remapper

This block sits between a removable card's host bus (common memory or I/O space) and the register port of an ATA task file. Each host access is a single-cycle strobe with address, write data and a read-data return all valid in that cycle. The block folds the host address into a 4-bit register index. The fold depends on a 2-bit addressing mode taken from the card's shared option register. A few indices are handled by the card itself: data, error/features, alternate status/device control, device address and the odd-byte latch. Every other index is forwarded unchanged to the task file.

The block owns the device-control register and a small byte-phase state machine. The state machine has two states. ST_EVEN is the reset state. ST_ODD is entered by transition T_TOGGLE, which is a write to the odd-byte index; the same transition leads from ST_ODD back to ST_EVEN. Transition T_SRST is a device-control write with the soft-reset bit set, and it forces ST_EVEN from either state. A forwarded register write made while the card is powered down also raises a one-cycle wake pulse. The surrounding card logic uses that pulse to clear its power-down flag and set its card-ready pin bit.

Top module: `ata_tf_remap`

## Requirements
- R1: With mode 0 (memory window), any address from 0x400 to 0x7FF maps to index 0. Every other address keeps its low four bits as the index.
- R2: With mode 1 (16-byte I/O), the index is the low four bits of the address.
- R3: With mode 2 (primary I/O), 0x3E8 is subtracted from addresses 0x3F0–0x3FF and 0x1F0 from addresses 0x1F0–0x1FF. The low four bits of the result form the index, so 0x3F6 gives 0xE and 0x1F7 gives 7.
- R4: With mode 3 (secondary I/O), 0x368 is subtracted from addresses 0x370–0x37F and 0x170 from addresses 0x170–0x17F. So 0x376 gives 0xE and 0x172 gives 2.
- R5: Indices 0 and 8 read and write 16-bit words of task-file register 0.
- R6: Index 0xD reaches task-file register 1, for both reads and writes.
- R7: A read of index 0xE returns the drive status byte when a drive is present and 0 otherwise. It makes no task-file access.
- R8: A write to index 0xE loads the low byte into the device-control output, one cycle later. If bit 2 of the written byte is set, the same cycle raises the soft-reset output. Device control then reads 0 and the byte phase returns to even.
- R9: A read of index 0xF returns 0xC2 ORed with bits 3..0 of the inverted device/head byte placed at bits 5..2.
- R10: A write to index 9 loads the low written byte into the odd-byte latch and flips the byte phase (0 = even, 1 = odd). It makes no task-file access. A read of index 9 returns the latch's upper byte, which is 0 after such a write.
- R11: A write forwarded on the default path (any index other than 0, 8, 9, 0xD, 0xE) raises the wake pulse when the power-down input is high. The write still reaches the task file. The pulse stays low without power-down, and it stays low for data and features writes.
- R12: After reset, device control is 0 and the byte phase is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Addressing mode from the option register |
| host_stb | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, same cycle |
| tf_stb | output | 1 | Task-file access strobe |
| tf_we | output | 1 | Task-file write enable |
| tf_idx | output | 4 | Task-file register index |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Drive status byte |
| dev_head | input | 8 | Drive device/head select byte |
| pwrdn | input | 1 | Card power-down flag |
| wake_pulse | output | 1 | Clear power-down and set card ready |
| soft_rst | output | 1 | Card soft reset request |
| dev_ctrl | output | 8 | Device-control register |
| byte_phase | output | 1 | Byte-cycle flag (0 = even, 1 = odd) |

## Verification
The device-control load and the soft reset fall in the same cycle whenever the written control byte carries bit 2. That write must set the reset request, leave the control register at 0 instead of the written value, and pull the byte phase out of ST_ODD even though no odd-byte access happened. The bench first moves the phase to odd with an odd-byte write, then writes 0x06 to index 0xE. It judges the same-cycle soft-reset output and, one cycle later, both device control and the phase. A plain 0x02 write is used as the contrast case.

// File: rtl/ata_remap_pkg.sv
package ata_remap_pkg;

    typedef enum logic [1:0] {
        MODE_MEM  = 2'd0,
        MODE_IO16 = 2'd1,
        MODE_PRI  = 2'd2,
        MODE_SEC  = 2'd3
    } fold_mode_e;

    typedef enum logic {
        ST_EVEN = 1'b0,
        ST_ODD  = 1'b1
    } phase_e;

    localparam logic [3:0] IDX_DATA    = 4'h0;
    localparam logic [3:0] IDX_DATA2   = 4'h8;
    localparam logic [3:0] IDX_ODD     = 4'h9;
    localparam logic [3:0] IDX_ERRFEAT = 4'hD;
    localparam logic [3:0] IDX_ALTCTL  = 4'hE;
    localparam logic [3:0] IDX_DEVADR  = 4'hF;
    localparam logic [3:0] TF_ERR_REG  = 4'h1;
    localparam int         SRST_BIT    = 2;
    localparam logic [7:0] DEVADR_BASE = 8'hC2;

endpackage

// File: rtl/ata_addr_fold.sv
module ata_addr_fold
    import ata_remap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        idx
);
    localparam int          WIN_SHIFT = 10;
    localparam int          BLK_SHIFT = 4;
    localparam logic [ADDR_W-1:0] PRI_HI_BLK = ADDR_W'(32'h3F);
    localparam logic [ADDR_W-1:0] PRI_LO_BLK = ADDR_W'(32'h1F);
    localparam logic [ADDR_W-1:0] SEC_HI_BLK = ADDR_W'(32'h37);
    localparam logic [ADDR_W-1:0] SEC_LO_BLK = ADDR_W'(32'h17);
    localparam logic [ADDR_W-1:0] PRI_HI_OFS = ADDR_W'(32'h3E8);
    localparam logic [ADDR_W-1:0] PRI_LO_OFS = ADDR_W'(32'h1F0);
    localparam logic [ADDR_W-1:0] SEC_HI_OFS = ADDR_W'(32'h368);
    localparam logic [ADDR_W-1:0] SEC_LO_OFS = ADDR_W'(32'h170);

    logic [ADDR_W-1:0] folded;
    logic [ADDR_W-1:0] blk;

    assign blk = addr >> BLK_SHIFT;

    always_comb begin
        folded = addr;
        unique case (fold_mode_e'(mode))
            MODE_MEM: begin
                if ((addr >> WIN_SHIFT) == ADDR_W'(1)) folded = '0;
            end
            MODE_IO16: folded = addr;
            MODE_PRI: begin
                if (blk == PRI_HI_BLK)      folded = addr - PRI_HI_OFS;
                else if (blk == PRI_LO_BLK) folded = addr - PRI_LO_OFS;
            end
            MODE_SEC: begin
                if (blk == SEC_HI_BLK)      folded = addr - SEC_HI_OFS;
                else if (blk == SEC_LO_BLK) folded = addr - SEC_LO_OFS;
            end
            default: folded = addr;
        endcase
    end

    assign idx = folded[3:0];

endmodule

// File: rtl/ata_byte_phase.sv
module ata_byte_phase
    import ata_remap_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              toggle,
    input  logic              clear,
    input  logic [7:0]        lo_byte,
    output logic              phase,
    output logic [HOLD_W-1:0] hold
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_EVEN;
        end else if (toggle) begin
            unique case (state_q)
                ST_EVEN: state_d = ST_ODD;
                ST_ODD:  state_d = ST_EVEN;
                default: state_d = ST_EVEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EVEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold <= '0;
        else if (toggle) hold <= HOLD_W'(lo_byte);
    end

    assign phase = (state_q == ST_ODD);

    // R10
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle && !clear |=> phase != $past(phase));

    // R8
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !phase);

endmodule

// File: rtl/ata_devctl.sv
module ata_devctl
    import ata_remap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] wbyte,
    output logic       srst,
    output logic [7:0] ctrl
);
    assign srst = load && wbyte[SRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctrl <= '0;
        else if (srst) ctrl <= '0;
        else if (load) ctrl <= wbyte;
    end

    // R8
    ctrl_srst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> ctrl == 8'h00);

    // R8
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && !wbyte[SRST_BIT] |=> ctrl == $past(wbyte));

endmodule

// File: rtl/ata_tf_remap.sv
module ata_tf_remap
    import ata_remap_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              host_stb,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tf_stb,
    output logic              tf_we,
    output logic [3:0]        tf_idx,
    output logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] tf_rdata,
    input  logic              drv_present,
    input  logic [7:0]        drv_status,
    input  logic [7:0]        dev_head,
    input  logic              pwrdn,
    output logic              wake_pulse,
    output logic              soft_rst,
    output logic [7:0]        dev_ctrl,
    output logic              byte_phase
);
    localparam int HOLD_W = 16;

    logic [3:0]        idx;
    logic              odd_wr;
    logic              ctl_wr;
    logic [HOLD_W-1:0] odd_hold;
    logic [7:0]        devadr;

    ata_addr_fold #(.ADDR_W(ADDR_W)) u_fold (
        .mode (mode),
        .addr (host_addr),
        .idx  (idx)
    );

    ata_byte_phase #(.HOLD_W(HOLD_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle  (odd_wr),
        .clear   (soft_rst),
        .lo_byte (host_wdata[7:0]),
        .phase   (byte_phase),
        .hold    (odd_hold)
    );

    ata_devctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl_wr),
        .wbyte (host_wdata[7:0]),
        .srst  (soft_rst),
        .ctrl  (dev_ctrl)
    );

    assign devadr = DEVADR_BASE | {2'b00, ~dev_head[3:0], 2'b00};

    always_comb begin
        tf_stb     = 1'b0;
        tf_we      = host_we;
        tf_idx     = idx;
        tf_wdata   = host_wdata;
        host_rdata = '0;
        odd_wr     = 1'b0;
        ctl_wr     = 1'b0;
        wake_pulse = 1'b0;
        if (host_stb) begin
            unique case (idx)
                IDX_DATA, IDX_DATA2: begin
                    tf_stb     = 1'b1;
                    tf_idx     = IDX_DATA;
                    host_rdata = tf_rdata;
                end
                IDX_ODD: begin
                    if (host_we) odd_wr = 1'b1;
                    else         host_rdata = DATA_W'(odd_hold[15:8]);
                end
                IDX_ERRFEAT: begin
                    tf_stb     = 1'b1;
                    tf_idx     = TF_ERR_REG;
                    host_rdata = tf_rdata;
                end
                IDX_ALTCTL: begin
                    if (host_we)          ctl_wr = 1'b1;
                    else if (drv_present) host_rdata = DATA_W'(drv_status);
                end
                IDX_DEVADR: begin
                    if (host_we) begin
                        tf_stb     = 1'b1;
                        wake_pulse = pwrdn;
                    end else begin
                        host_rdata = DATA_W'(devadr);
                    end
                end
                default: begin
                    tf_stb     = 1'b1;
                    host_rdata = tf_rdata;
                    wake_pulse = host_we && pwrdn;
                end
            endcase
        end
    end

    // R1
    mem_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_stb && mode == 2'd0 && (host_addr >> 10) == ADDR_W'(1)
        |-> tf_stb && tf_idx == 4'h0);

    // R5
    data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_stb && (idx == 4'h0 || idx == 4'h8) |-> tf_stb && tf_idx == 4'h0);

    // R11
    wake_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> tf_stb && tf_we && pwrdn);

    // R7
    alt_no_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_stb && idx == 4'hE |-> !tf_stb);

endmodule

// File: tb/ata_tf_remap_tb.sv
module ata_tf_remap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        host_stb = 1'b0;
    logic        host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        tf_stb, tf_we;
    logic [3:0]  tf_idx;
    logic [15:0] tf_wdata;
    logic [15:0] tf_rdata;
    logic        drv_present = 1'b1;
    logic [7:0]  drv_status = 8'h50;
    logic [7:0]  dev_head = 8'hA0;
    logic        pwrdn = 1'b0;
    logic        wake_pulse, soft_rst, byte_phase;
    logic [7:0]  dev_ctrl;

    int checks = 0;
    int failures = 0;

    logic [15:0] c_rd, c_twd;
    logic        c_tstb, c_twe, c_wake, c_srst;
    logic [3:0]  c_tidx;

    logic [15:0] tf_regs [16];

    always #10 clk = ~clk;

    assign tf_rdata = tf_regs[tf_idx];
    always @(posedge clk) if (tf_stb && tf_we) tf_regs[tf_idx] <= tf_wdata;

    ata_tf_remap u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .host_stb(host_stb), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tf_stb(tf_stb), .tf_we(tf_we), .tf_idx(tf_idx),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .drv_present(drv_present), .drv_status(drv_status),
        .dev_head(dev_head), .pwrdn(pwrdn), .wake_pulse(wake_pulse),
        .soft_rst(soft_rst), .dev_ctrl(dev_ctrl), .byte_phase(byte_phase)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        host_stb = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        #1;
        c_rd = host_rdata; c_tstb = tf_stb; c_twe = tf_we; c_tidx = tf_idx;
        c_twd = tf_wdata; c_wake = wake_pulse; c_srst = soft_rst;
        @(posedge clk);
        #1;
        host_stb = 1'b0; host_we = 1'b0;
    endtask

    task automatic t_reset;
        chk(dev_ctrl == 8'h00, "R12 ctrl", 32'(dev_ctrl), 32'h0);
        chk(byte_phase == 1'b0, "R12 phase", 32'(byte_phase), 32'h0);
    endtask

    task automatic t_mem;
        mode = 2'd0;
        acc(1'b1, 11'h5A5, 16'h1234);
        chk(c_tstb && c_twe && c_tidx == 4'h0, "R1 mem write idx", 32'(c_tidx), 32'h0);
        acc(1'b0, 11'h400, 16'h0);
        chk(c_rd == 16'h1234, "R1 mem read data", 32'(c_rd), 32'h1234);
        acc(1'b1, 11'h003, 16'h3333);
        chk(c_tstb && c_tidx == 4'h3, "R1 mem pass idx", 32'(c_tidx), 32'h3);
        acc(1'b0, 11'h7FF, 16'h0);
        chk(c_tidx == 4'h0 && c_rd == 16'h1234, "R1 mem top edge", 32'(c_rd), 32'h1234);
    endtask

    task automatic t_io16;
        mode = 2'd1;
        acc(1'b0, 11'h7F3, 16'h0);
        chk(c_tstb && c_tidx == 4'h3 && c_rd == 16'h3333, "R2 io16 idx", 32'(c_rd), 32'h3333);
        acc(1'b1, 11'h008, 16'hBEEF);
        chk(c_tstb && c_tidx == 4'h0 && c_twd == 16'hBEEF, "R5 idx8 write", 32'(c_tidx), 32'h0);
        acc(1'b0, 11'h000, 16'h0);
        chk(c_rd == 16'hBEEF, "R5 idx0 read", 32'(c_rd), 32'hBEEF);
        acc(1'b1, 11'h00D, 16'h0077);
        chk(c_tstb && c_twe && c_tidx == 4'h1, "R6 features write", 32'(c_tidx), 32'h1);
        acc(1'b0, 11'h00D, 16'h0);
        chk(!c_twe && c_tidx == 4'h1 && c_rd == 16'h0077, "R6 error read", 32'(c_rd), 32'h77);
    endtask

    task automatic t_pri;
        mode = 2'd2;
        acc(1'b0, 11'h1F7, 16'h0);
        chk(c_tstb && c_tidx == 4'h7, "R3 primary low", 32'(c_tidx), 32'h7);
        drv_present = 1'b1; drv_status = 8'h58;
        acc(1'b0, 11'h3F6, 16'h0);
        chk(!c_tstb && c_rd == 16'h0058, "R7 alt status", 32'(c_rd), 32'h58);
        drv_present = 1'b0;
        acc(1'b0, 11'h3F6, 16'h0);
        chk(c_rd == 16'h0000, "R7 no drive", 32'(c_rd), 32'h0);
        drv_present = 1'b1;
        dev_head = 8'hA3;
        acc(1'b0, 11'h3F7, 16'h0);
        chk(!c_tstb && c_rd == 16'h00F2, "R9 devaddr A3", 32'(c_rd), 32'hF2);
        dev_head = 8'hAF;
        acc(1'b0, 11'h3F7, 16'h0);
        chk(c_rd == 16'h00C2, "R9 devaddr AF", 32'(c_rd), 32'hC2);
    endtask

    task automatic t_sec;
        mode = 2'd3;
        acc(1'b0, 11'h172, 16'h0);
        chk(c_tstb && c_tidx == 4'h2, "R4 secondary low", 32'(c_tidx), 32'h2);
        acc(1'b1, 11'h376, 16'h0002);
        chk(!c_tstb && !c_srst, "R4 secondary ctl no tf", 32'(c_tstb), 32'h0);
        chk(dev_ctrl == 8'h02, "R8 ctrl load", 32'(dev_ctrl), 32'h2);
    endtask

    task automatic t_odd;
        mode = 2'd1;
        acc(1'b1, 11'h009, 16'hABCD);
        chk(!c_tstb && byte_phase == 1'b1, "R10 odd write toggles", 32'(byte_phase), 32'h1);
        acc(1'b0, 11'h009, 16'h0);
        chk(!c_tstb && c_rd == 16'h0000, "R10 odd read upper", 32'(c_rd), 32'h0);
        acc(1'b1, 11'h009, 16'h0011);
        chk(byte_phase == 1'b0, "R10 toggle back", 32'(byte_phase), 32'h0);
    endtask

    task automatic t_srst;
        mode = 2'd1;
        acc(1'b1, 11'h009, 16'h0055);
        chk(byte_phase == 1'b1, "R10 phase odd before reset", 32'(byte_phase), 32'h1);
        acc(1'b1, 11'h00E, 16'h0006);
        chk(c_srst == 1'b1, "R8 soft reset pulse", 32'(c_srst), 32'h1);
        chk(dev_ctrl == 8'h00, "R8 ctrl cleared", 32'(dev_ctrl), 32'h0);
        chk(byte_phase == 1'b0, "R8 phase even", 32'(byte_phase), 32'h0);
    endtask

    task automatic t_pwr;
        mode = 2'd1;
        pwrdn = 1'b1;
        acc(1'b1, 11'h003, 16'h4444);
        chk(c_wake && c_tstb && c_twe && c_tidx == 4'h3, "R11 wake on forward", 32'(c_wake), 32'h1);
        acc(1'b0, 11'h003, 16'h0);
        chk(c_rd == 16'h4444 && !c_wake, "R11 write reached tf", 32'(c_rd), 32'h4444);
        acc(1'b1, 11'h000, 16'h1111);
        chk(!c_wake, "R11 no wake on data", 32'(c_wake), 32'h0);
        acc(1'b1, 11'h00D, 16'h0001);
        chk(!c_wake, "R11 no wake on features", 32'(c_wake), 32'h0);
        pwrdn = 1'b0;
        acc(1'b1, 11'h005, 16'h0005);
        chk(!c_wake && c_tidx == 4'h5, "R11 no wake powered", 32'(c_wake), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tf_regs[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mem();
        t_io16();
        t_pri();
        t_sec();
        t_odd();
        t_srst();
        t_pwr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule